// File: doc/BRIEF.md
# Three-Stage Forwarding Pipeline Core

This block is a small in-order datapath that executes one instruction per clock from a five-opcode set: load an immediate, bitwise AND, bitwise OR, read out a register (STORE) and no-operation. Every cycle the upstream source presents an opcode, an immediate, two source register indices and a destination index. The first stage captures the instruction and resolves its two operands. The second stage computes the logic result. The third stage writes that result into the register file.

Operands that are still in flight are forwarded, so arithmetic dependencies never cost a cycle. The only interlock is for a STORE whose register is about to be written by an instruction in stage one or stage two. In that case the core raises its stall output and inserts a bubble, and the source keeps the same instruction on its inputs until stall drops. The read-out port always shows the register named by the destination input, combinationally. Word width and register count are parameters.

Top module: `fwd_pipe3_core`

## Requirements
- R1: Reset is synchronous and active low. After reset every register reads zero, both pipeline stages hold NOP, and a STORE issued right after reset does not stall.
- R2: The opcode is encoded on 3 bits as LOAD=0, AND=1, OR=2, STORE=3 and NOP=4. An accepted LOAD writes its immediate into the destination register, and a later STORE of that register reads the same value back.
- R3: An accepted AND or OR writes the bitwise AND or bitwise OR of its two source registers into the destination register.
- R4: An operand whose register is written by the instruction directly ahead (now in stage one) takes that instruction's value. This is the immediate for a LOAD and the logic result for AND or OR, so back-to-back dependent instructions produce the architectural result without stalling.
- R5: An operand whose register is written by the instruction two slots ahead (now in stage two) takes that instruction's result. When both slots write the register, the younger one (stage one) wins.
- R6: Stall is high exactly when the incoming opcode is STORE and its destination equals the destination of an AND, OR or LOAD in stage one or stage two. Stall never rises for any other opcode, nor for a matching NOP or STORE ahead.
- R7: In a stalled cycle a NOP enters stage one in place of the incoming instruction and the stage-one operands keep their values. The held instruction is executed exactly once, after stall drops.
- R8: NOP and STORE never modify any register, whatever their immediate and destination fields hold. The stage-two result keeps its value while a non-writing instruction passes.
- R9: The read-out output equals register[destination input] in the same cycle the STORE is presented with stall low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Opcode of the incoming instruction |
| imm_i | input | W | Immediate for LOAD |
| src_a_i | input | clog2(NREG) | First source register index |
| src_b_i | input | clog2(NREG) | Second source register index |
| dst_i | input | clog2(NREG) | Destination register (read register for STORE) |
| stall_o | output | 1 | Incoming STORE must be held for another cycle |
| rd_data_o | output | W | Value of register[dst_i] |

## Verification
Stall and read-out are combinational, so the bench checks both 1 ns after it drives an instruction on the falling edge, in the same cycle as the instruction. A written register is architecturally visible to a STORE that arrives as early as the next cycle. Until the writer has left stage two, that STORE is held, which takes two stall cycles directly behind a writer and one with a single slot between them. The bench predicts these cycle counts by tracking the opcodes and destinations of the two instructions it has handed to the core. For each expected stall cycle it checks the flag, then waits one edge before checking again, and it compares the read-out only in the cycle where the STORE is accepted.

// File: rtl/fp3_pkg.sv
// Shared opcode type and opcode classification for the pipeline core.
package fp3_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_AND   = 3'd1,
        OP_OR    = 3'd2,
        OP_STORE = 3'd3,
        OP_NOP   = 3'd4
    } fp3_op_e;

    // True for opcodes that produce a register write.
    function automatic logic fp3_writes(input fp3_op_e op);
        return (op == OP_LOAD) || (op == OP_AND) || (op == OP_OR);
    endfunction

endpackage

// File: rtl/fp3_regfile.sv
// Register file: one synchronous write port, NRD combinational read ports.
// Assumes: the write index is below NREG; reset clears every entry.
module fp3_regfile #(
    parameter int W    = 8,
    parameter int NREG = 8,
    parameter int NRD  = 3,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IW-1:0]           wa,
    input  logic [W-1:0]            wd,
    input  logic [NRD-1:0][IW-1:0]  ra,
    output logic [NRD-1:0][W-1:0]   rd
);
    logic [W-1:0] mem [NREG];

    // Write port with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    // Read ports, one per requester.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd[p] = mem[ra[p]];
    end
endmodule

// File: rtl/fp3_fwd_mux.sv
// Operand selector: picks the youngest in-flight value for one source index.
// Assumes: s1_val already resolves LOAD immediate versus logic result.
module fp3_fwd_mux
    import fp3_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [IW-1:0] src,
    input  fp3_op_e       s1_op,
    input  logic [IW-1:0] s1_dst,
    input  logic [W-1:0]  s1_val,
    input  fp3_op_e       s2_op,
    input  logic [IW-1:0] s2_dst,
    input  logic [W-1:0]  s2_val,
    input  logic [W-1:0]  rf_val,
    output logic [W-1:0]  opnd
);
    // Priority: stage one, then stage two, then register file.
    always_comb begin
        if (fp3_writes(s1_op) && (src == s1_dst))      opnd = s1_val;
        else if (fp3_writes(s2_op) && (src == s2_dst)) opnd = s2_val;
        else                                           opnd = rf_val;
    end
endmodule

// File: rtl/fp3_hazard.sv
// STORE interlock: flags a STORE whose register still has a writer in flight.
// Assumes: no other opcode needs an interlock, forwarding covers the rest.
module fp3_hazard
    import fp3_pkg::*;
#(
    parameter int IW = 3
) (
    input  fp3_op_e       op_in,
    input  logic [IW-1:0] dst_in,
    input  fp3_op_e       s1_op,
    input  logic [IW-1:0] s1_dst,
    input  fp3_op_e       s2_op,
    input  logic [IW-1:0] s2_dst,
    output logic          stall
);
    logic hit1, hit2;

    // Compare the STORE register against both in-flight writers.
    always_comb begin
        hit1  = fp3_writes(s1_op) && (dst_in == s1_dst);
        hit2  = fp3_writes(s2_op) && (dst_in == s2_dst);
        stall = (op_in == OP_STORE) && (hit1 || hit2);
    end
endmodule

// File: rtl/fwd_pipe3_core.sv
// Three-stage in-order core: operand fetch with forwarding, logic unit,
// register write-back. Assumes the source holds its inputs while stall_o is high.
module fwd_pipe3_core
    import fp3_pkg::*;
#(
    parameter int W    = 8,
    parameter int NREG = 8,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [W-1:0]  imm_i,
    input  logic [IW-1:0] src_a_i,
    input  logic [IW-1:0] src_b_i,
    input  logic [IW-1:0] dst_i,
    output logic          stall_o,
    output logic [W-1:0]  rd_data_o
);
    localparam int NOPND = 2;

    fp3_op_e op_in;
    assign op_in = fp3_op_e'(op_i);

    // Stage one state
    fp3_op_e s1_op;
    logic [IW-1:0] s1_dst;
    logic [W-1:0]  s1_imm;
    logic [NOPND-1:0][W-1:0] s1_opnd;

    // Stage two state
    fp3_op_e s2_op;
    logic [IW-1:0] s2_dst;
    logic [W-1:0]  s2_res;

    logic [W-1:0] alu_res, s1_val;
    logic [NOPND-1:0][W-1:0]  opnd_nxt;
    logic [2:0][IW-1:0]       rf_ra;
    logic [2:0][W-1:0]        rf_rd;
    logic [NOPND-1:0][IW-1:0] srcs;
    logic stall;

    assign srcs  = {src_b_i, src_a_i};
    assign rf_ra = {dst_i, src_b_i, src_a_i};

    // Logic unit on the stage-one operands.
    always_comb begin
        alu_res = (s1_op == OP_AND) ? (s1_opnd[0] & s1_opnd[1])
                                    : (s1_opnd[0] | s1_opnd[1]);
        s1_val  = (s1_op == OP_LOAD) ? s1_imm : alu_res;
    end

    fp3_regfile #(.W(W), .NREG(NREG), .NRD(3)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fp3_writes(s2_op)),
        .wa    (s2_dst),
        .wd    (s2_res),
        .ra    (rf_ra),
        .rd    (rf_rd)
    );

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        fp3_fwd_mux #(.W(W), .IW(IW)) u_mux (
            .src    (srcs[g]),
            .s1_op  (s1_op),
            .s1_dst (s1_dst),
            .s1_val (s1_val),
            .s2_op  (s2_op),
            .s2_dst (s2_dst),
            .s2_val (s2_res),
            .rf_val (rf_rd[g]),
            .opnd   (opnd_nxt[g])
        );
    end

    fp3_hazard #(.IW(IW)) u_haz (
        .op_in  (op_in),
        .dst_in (dst_i),
        .s1_op  (s1_op),
        .s1_dst (s1_dst),
        .s2_op  (s2_op),
        .s2_dst (s2_dst),
        .stall  (stall)
    );

    // Stage one: capture instruction, bubble and hold operands on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= OP_NOP;
            s1_dst  <= '0;
            s1_imm  <= '0;
            s1_opnd <= '0;
        end else begin
            s1_op  <= stall ? OP_NOP : op_in;
            s1_dst <= dst_i;
            s1_imm <= imm_i;
            if (!stall) s1_opnd <= opnd_nxt;
        end
    end

    // Stage two: carry control, latch result of writing opcodes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op  <= OP_NOP;
            s2_dst <= '0;
            s2_res <= '0;
        end else begin
            s2_op  <= s1_op;
            s2_dst <= s1_dst;
            if (fp3_writes(s1_op)) s2_res <= s1_val;
        end
    end

    assign stall_o   = stall;
    assign rd_data_o = rf_rd[2];
endmodule

// File: rtl/fp3_checker.sv
// Temporal checks on the core's pipeline control, attached by bind.
module fp3_checker
    import fp3_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input fp3_op_e      op_in,
    input logic         stall,
    input fp3_op_e      s1_op,
    input fp3_op_e      s2_op,
    input logic [W-1:0] s1_opa,
    input logic [W-1:0] s1_opb,
    input logic [W-1:0] s2_res
);
    AST_STALL_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (op_in == OP_STORE)); // R6

    AST_NO_WRITER_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!fp3_writes(s1_op) && !fp3_writes(s2_op)) |-> !stall); // R6

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (s1_op == OP_NOP)); // R7

    AST_STALL_OPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(s1_opa) && $stable(s1_opb))); // R7

    AST_ISSUE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (s1_op == $past(op_in))); // R7

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fp3_writes(s1_op) |=> $stable(s2_res)); // R8
endmodule

bind fwd_pipe3_core fp3_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_in  (op_in),
    .stall  (stall),
    .s1_op  (s1_op),
    .s2_op  (s2_op),
    .s1_opa (s1_opnd[0]),
    .s1_opb (s1_opnd[1]),
    .s2_res (s2_res)
);

// File: tb/sim_fwd_pipe3_core.sv
// Directed bench: architectural register model plus a two-slot shadow of
// in-flight opcodes to predict stall cycles.
module sim_fwd_pipe3_core;
    import fp3_pkg::*;

    localparam int W    = 8;
    localparam int NREG = 8;
    localparam int IW   = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_drv = 3'd4;
    logic [W-1:0]  imm_drv = '0;
    logic [IW-1:0] sa_drv = '0, sb_drv = '0, d_drv = '0;
    logic          stall_o;
    logic [W-1:0]  rd_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] model [NREG];
    fp3_op_e sh1_op = OP_NOP, sh2_op = OP_NOP;
    logic [IW-1:0] sh1_d = '0, sh2_d = '0;

    always #10 clk = ~clk;

    fwd_pipe3_core #(.W(W), .NREG(NREG)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_drv),
        .imm_i     (imm_drv),
        .src_a_i   (sa_drv),
        .src_b_i   (sb_drv),
        .dst_i     (d_drv),
        .stall_o   (stall_o),
        .rd_data_o (rd_data_o)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic writes(input fp3_op_e o);
        return (o == OP_LOAD) || (o == OP_AND) || (o == OP_OR);
    endfunction

    // Present one instruction, follow expected stalls, update model and shadow.
    task automatic issue(input fp3_op_e op, input logic [W-1:0] imm,
                         input int a, input int b, input int d, input string req);
        logic exp_st;
        @(negedge clk);
        op_drv = op; imm_drv = imm;
        sa_drv = IW'(a); sb_drv = IW'(b); d_drv = IW'(d);
        forever begin
            #1;
            exp_st = (op == OP_STORE) &&
                     ((writes(sh1_op) && sh1_d == IW'(d)) ||
                      (writes(sh2_op) && sh2_d == IW'(d)));
            check("R6", "stall", W'(stall_o), W'(exp_st));
            if (!exp_st) break;
            @(posedge clk);
            sh2_op = sh1_op; sh2_d = sh1_d;
            sh1_op = OP_NOP; sh1_d = IW'(d);
            @(negedge clk);
        end
        case (op)
            OP_STORE: check(req, $sformatf("read-out r%0d", d), rd_data_o, model[d]);
            OP_LOAD:  model[d] = imm;
            OP_AND:   model[d] = model[a] & model[b];
            OP_OR:    model[d] = model[a] | model[b];
            default: ;
        endcase
        @(posedge clk);
        sh2_op = sh1_op; sh2_d = sh1_d;
        sh1_op = op; sh1_d = IW'(d);
    endtask

    task automatic nop(); issue(OP_NOP, '0, 0, 0, 0, "R8"); endtask

    task automatic t_reset();
        for (int r = 0; r < NREG; r++) issue(OP_STORE, '0, 0, 0, r, "R1 R9");
    endtask

    task automatic t_load_store();
        issue(OP_LOAD, 8'h3C, 0, 0, 1, "R2");
        nop(); nop();
        issue(OP_STORE, '0, 0, 0, 1, "R2");
        issue(OP_LOAD, 8'hC3, 0, 0, 6, "R2");
        issue(OP_STORE, '0, 0, 0, 6, "R2");
    endtask

    task automatic t_logic();
        issue(OP_LOAD, 8'hF0, 0, 0, 2, "R3");
        issue(OP_LOAD, 8'h3C, 0, 0, 3, "R3");
        nop(); nop();
        issue(OP_AND, '0, 2, 3, 4, "R3");
        issue(OP_OR,  '0, 2, 3, 5, "R3");
        nop(); nop();
        issue(OP_STORE, '0, 0, 0, 4, "R3");
        issue(OP_STORE, '0, 0, 0, 5, "R3");
    endtask

    task automatic t_fwd_stage1();
        issue(OP_LOAD, 8'hA5, 0, 0, 1, "R4");
        issue(OP_AND, '0, 1, 1, 6, "R4");
        issue(OP_OR,  '0, 6, 3, 7, "R4");
        issue(OP_AND, '0, 7, 2, 7, "R4");
        nop(); nop();
        issue(OP_STORE, '0, 0, 0, 6, "R4");
        issue(OP_STORE, '0, 0, 0, 7, "R4");
    endtask

    task automatic t_fwd_stage2();
        issue(OP_LOAD, 8'h11, 0, 0, 1, "R5");
        nop();
        issue(OP_OR, '0, 1, 2, 6, "R5");
        issue(OP_LOAD, 8'h22, 0, 0, 1, "R5");
        issue(OP_LOAD, 8'h44, 0, 0, 1, "R5");
        issue(OP_OR, '0, 1, 1, 7, "R5");
        nop(); nop();
        issue(OP_STORE, '0, 0, 0, 6, "R5");
        issue(OP_STORE, '0, 0, 0, 7, "R5");
    endtask

    task automatic t_stall();
        issue(OP_LOAD, 8'h5A, 0, 0, 3, "R6");
        issue(OP_STORE, '0, 0, 0, 3, "R6 R9");
        issue(OP_LOAD, 8'h77, 0, 0, 3, "R6");
        nop();
        issue(OP_STORE, '0, 0, 0, 3, "R6");
        issue(OP_LOAD, 8'h01, 0, 0, 3, "R6");
        issue(OP_STORE, '0, 0, 0, 2, "R6");
        issue(OP_STORE, '0, 0, 0, 2, "R6");
        issue(OP_NOP, 8'hFF, 0, 0, 2, "R6");
        issue(OP_STORE, '0, 0, 0, 2, "R6");
    endtask

    task automatic t_bubble();
        issue(OP_LOAD, 8'h0F, 0, 0, 5, "R7");
        issue(OP_STORE, '0, 0, 0, 5, "R7");
        issue(OP_OR, '0, 5, 2, 5, "R7");
        issue(OP_AND, '0, 5, 4, 4, "R7");
        nop(); nop();
        issue(OP_STORE, '0, 0, 0, 4, "R7");
        issue(OP_STORE, '0, 0, 0, 5, "R7");
    endtask

    task automatic t_no_write();
        issue(OP_STORE, 8'hEE, 4, 4, 4, "R8");
        issue(OP_NOP, 8'hDD, 4, 4, 4, "R8");
        nop(); nop();
        issue(OP_STORE, '0, 0, 0, 4, "R8");
        issue(OP_LOAD, 8'h99, 0, 0, 0, "R8");
        issue(OP_NOP, 8'h12, 1, 1, 0, "R8");
        issue(OP_NOP, 8'h34, 1, 1, 0, "R8");
        issue(OP_STORE, '0, 0, 0, 0, "R8");
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) model[r] = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_store();
        t_logic();
        t_fwd_stage1();
        t_fwd_stage2();
        t_stall();
        t_bubble();
        t_no_write();
        repeat (2) @(posedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule